// File: doc/BRIEF.md
# CAN Mailbox Status Controller

This block tracks the life cycle of one CAN message buffer. It holds a 4-bit state code, a 4-bit data length code and a 4-bit transmit priority. Software reads and writes these three fields as one 16-bit status/control word. Hardware event strobes from the receive path, the transmit path and the remote-frame matcher move the state through its receive and transmit sequences.

The receive side tells a first copy of a frame apart from a copy that lands on a buffer already holding data. The second case ends in an overrun state. On the transmit side, a mailbox can answer remote requests by itself. It sends its frame once and then returns to a waiting state, ready for the next request. After the mailbox sends a remote request of its own, it switches itself to receive-ready so that the answer can land in the same buffer.

Frame storage, the bus protocol and arbitration between mailboxes sit outside this block.

Top module: `mbox_status_ctrl`

## Requirements
- R1: After reset, the status/control word reads 0x0000 and busy_o is low.
- R2: The word carries the length code in bits 15..12, the priority in bits 7..4 and the state in bits 3..0. Bits 11..8 always read zero. A software write loads all three fields, and the bits written at 11..8 are dropped.
- R3: An accepted frame moves the state from ready 0010 to first-copy busy 0011, from full 0100 to second-copy busy 0101, and from overrun 0110 to overrun-copy busy 0111. Accept strobes in any other state, and transmit strobes in receive states, leave the word unchanged.
- R4: When a copy finishes, state 0011 moves to full 0100, and states 0101 and 0111 move to overrun 0110. In each case the length code is loaded from rx_dlc_i.
- R5: A software write of state 0000 while the state is 0011, 0101 or 0111 yields busy code 0001, unless copy_done_i is high in the same cycle, in which case it yields 0000. A copy finishing in state 0001 moves it to 0000 and leaves the length code unchanged.
- R6: A transmit start moves send-once 1100 to busy 1101. A transmit done for a data frame moves 1101 to transmit-not-active 1000.
- R7: A transmit done with tx_remote_i high moves 1101 to receive-ready 0010.
- R8: A transmit start moves send-once-then-reply 1110 to busy 1111. A transmit done moves 1111 to automatic-reply 1010.
- R9: A matching remote request received in state 1010 moves the state to 1110.
- R10: A software write of the unused codes 1001 or 1011 stores 1000.
- R11: A software write takes priority over every hardware event in the same cycle, apart from the copy-done case in R5.
- R12: busy_o is high exactly in states 0001, 0011, 0101, 0111, 1101 and 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wr_i | input | 1 | Software write strobe for the status/control word |
| sw_wdata_i | input | 16 | Status/control word written by software |
| accept_i | input | 1 | Frame accepted for this mailbox; copy begins |
| copy_done_i | input | 1 | Copy of the received frame has finished |
| rx_dlc_i | input | 4 | Length code of the received frame |
| tx_start_i | input | 1 | This mailbox has started transmitting |
| tx_done_i | input | 1 | Transmission finished |
| tx_remote_i | input | 1 | The finished transmission was a remote request |
| rtr_rx_i | input | 1 | Matching remote request received |
| stat_word_o | output | 16 | Status/control word |
| state_o | output | 4 | Current state code |
| busy_o | output | 1 | State is one of the busy codes |

## Verification
Software deactivating the mailbox and the hardware finishing a copy can fall in the same cycle. The bench provokes this by writing state 0000 in the cycle where copy_done_i pulses on a mailbox in 0011, and it expects 0000 rather than 0001. It also pulses copy_done_i one cycle after such a write and checks that 0001 drains to 0000. A software write that coincides with accept_i is checked as well: the written word must win.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int STATE_W  = 4;
  localparam int DLC_W    = 4;
  localparam int PRIO_W   = 4;
  localparam int WORD_W   = 16;
  localparam int DLC_LSB  = WORD_W - DLC_W;
  localparam int PRIO_LSB = STATE_W;
  localparam int GAP_W    = DLC_LSB - PRIO_LSB - PRIO_W;

  typedef enum logic [STATE_W-1:0] {
    MB_RX_OFF       = 4'b0000,
    MB_RX_BUSY_SW   = 4'b0001,
    MB_RX_RDY       = 4'b0010,
    MB_RX_BUSY_1ST  = 4'b0011,
    MB_RX_FULL      = 4'b0100,
    MB_RX_BUSY_2ND  = 4'b0101,
    MB_RX_OVR       = 4'b0110,
    MB_RX_BUSY_OVR  = 4'b0111,
    MB_TX_OFF       = 4'b1000,
    MB_TX_RTR       = 4'b1010,
    MB_TX_ONCE      = 4'b1100,
    MB_TX_BUSY_ONCE = 4'b1101,
    MB_TX_ONCE_RTR  = 4'b1110,
    MB_TX_BUSY_RTR  = 4'b1111
  } mb_state_e;

  function automatic mb_state_e decode_state(logic [STATE_W-1:0] code);
    case (code)
      4'b0000: return MB_RX_OFF;
      4'b0001: return MB_RX_BUSY_SW;
      4'b0010: return MB_RX_RDY;
      4'b0011: return MB_RX_BUSY_1ST;
      4'b0100: return MB_RX_FULL;
      4'b0101: return MB_RX_BUSY_2ND;
      4'b0110: return MB_RX_OVR;
      4'b0111: return MB_RX_BUSY_OVR;
      4'b1010: return MB_TX_RTR;
      4'b1100: return MB_TX_ONCE;
      4'b1101: return MB_TX_BUSY_ONCE;
      4'b1110: return MB_TX_ONCE_RTR;
      4'b1111: return MB_TX_BUSY_RTR;
      default: return MB_TX_OFF;
    endcase
  endfunction

  function automatic logic is_copying(mb_state_e s);
    return (s == MB_RX_BUSY_1ST) || (s == MB_RX_BUSY_2ND) || (s == MB_RX_BUSY_OVR);
  endfunction
endpackage

// File: rtl/mbox_rx_seq.sv
module mbox_rx_seq
  import mbox_pkg::*;
(
  input  mb_state_e cur_i,
  input  logic      accept_i,
  input  logic      copy_done_i,
  output mb_state_e nxt_o,
  output logic      load_dlc_o
);
  always_comb begin
    nxt_o      = cur_i;
    load_dlc_o = 1'b0;
    case (cur_i)
      MB_RX_RDY:      if (accept_i) nxt_o = MB_RX_BUSY_1ST;
      MB_RX_FULL:     if (accept_i) nxt_o = MB_RX_BUSY_2ND;
      MB_RX_OVR:      if (accept_i) nxt_o = MB_RX_BUSY_OVR;
      MB_RX_BUSY_SW:  if (copy_done_i) nxt_o = MB_RX_OFF;
      MB_RX_BUSY_1ST: if (copy_done_i) begin
        nxt_o      = MB_RX_FULL;
        load_dlc_o = 1'b1;
      end
      MB_RX_BUSY_2ND, MB_RX_BUSY_OVR: if (copy_done_i) begin
        nxt_o      = MB_RX_OVR;
        load_dlc_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbox_tx_seq.sv
module mbox_tx_seq
  import mbox_pkg::*;
(
  input  mb_state_e cur_i,
  input  logic      tx_start_i,
  input  logic      tx_done_i,
  input  logic      tx_remote_i,
  input  logic      rtr_rx_i,
  output mb_state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    case (cur_i)
      MB_TX_ONCE:      if (tx_start_i) nxt_o = MB_TX_BUSY_ONCE;
      MB_TX_ONCE_RTR:  if (tx_start_i) nxt_o = MB_TX_BUSY_RTR;
      MB_TX_BUSY_ONCE: if (tx_done_i)  nxt_o = tx_remote_i ? MB_RX_RDY : MB_TX_OFF;
      MB_TX_BUSY_RTR:  if (tx_done_i)  nxt_o = MB_TX_RTR;
      MB_TX_RTR:       if (rtr_rx_i)   nxt_o = MB_TX_ONCE_RTR;
      default: ;
    endcase
  end
endmodule

// File: rtl/mbox_sw_merge.sv
module mbox_sw_merge
  import mbox_pkg::*;
(
  input  mb_state_e          cur_i,
  input  logic [STATE_W-1:0] wr_code_i,
  input  logic               copy_done_i,
  output mb_state_e          nxt_o
);
  mb_state_e req;
  assign req = decode_state(wr_code_i);

  // deactivation cannot cut a running copy short
  always_comb begin
    nxt_o = req;
    if (req == MB_RX_OFF && is_copying(cur_i) && !copy_done_i) nxt_o = MB_RX_BUSY_SW;
  end
endmodule

// File: rtl/mbox_status_ctrl.sv
module mbox_status_ctrl
  import mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_wr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  input  logic              accept_i,
  input  logic              copy_done_i,
  input  logic [DLC_W-1:0]  rx_dlc_i,
  input  logic              tx_start_i,
  input  logic              tx_done_i,
  input  logic              tx_remote_i,
  input  logic              rtr_rx_i,
  output logic [WORD_W-1:0] stat_word_o,
  output logic [STATE_W-1:0] state_o,
  output logic              busy_o
);
  mb_state_e          state_q, rx_nxt, tx_nxt, sw_nxt;
  logic [DLC_W-1:0]   dlc_q;
  logic [PRIO_W-1:0]  prio_q;
  logic               rx_load_dlc;
  logic               unused_gap;

  assign unused_gap = ^sw_wdata_i[DLC_LSB-1 -: GAP_W];

  mbox_rx_seq u_rx (
    .cur_i(state_q), .accept_i(accept_i), .copy_done_i(copy_done_i),
    .nxt_o(rx_nxt), .load_dlc_o(rx_load_dlc)
  );

  mbox_tx_seq u_tx (
    .cur_i(state_q), .tx_start_i(tx_start_i), .tx_done_i(tx_done_i),
    .tx_remote_i(tx_remote_i), .rtr_rx_i(rtr_rx_i), .nxt_o(tx_nxt)
  );

  mbox_sw_merge u_sw (
    .cur_i(state_q), .wr_code_i(sw_wdata_i[STATE_W-1:0]),
    .copy_done_i(copy_done_i), .nxt_o(sw_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MB_RX_OFF;
      dlc_q   <= '0;
      prio_q  <= '0;
    end else if (sw_wr_i) begin
      state_q <= sw_nxt;
      dlc_q   <= sw_wdata_i[DLC_LSB +: DLC_W];
      prio_q  <= sw_wdata_i[PRIO_LSB +: PRIO_W];
    end else if (state_q[STATE_W-1]) begin
      state_q <= tx_nxt;
    end else begin
      state_q <= rx_nxt;
      if (rx_load_dlc) dlc_q <= rx_dlc_i;
    end
  end

  assign state_o     = state_q;
  assign stat_word_o = {dlc_q, {GAP_W{1'b0}}, prio_q, state_q};
  assign busy_o      = state_q[0] && (!state_q[STATE_W-1] || state_q[2]);

  assert_accept_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'b0010 && accept_i && !sw_wr_i) |=> state_o == 4'b0011);

  assert_first_copy_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'b0011 && copy_done_i && !sw_wr_i) |=>
      (state_o == 4'b0100 && stat_word_o[DLC_LSB +: DLC_W] == $past(rx_dlc_i)));

  assert_sw_off_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && sw_wdata_i[STATE_W-1:0] == 4'b0000 && !copy_done_i &&
     (state_o == 4'b0011 || state_o == 4'b0101 || state_o == 4'b0111)) |=> state_o == 4'b0001);

  assert_remote_req_sent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'b1101 && tx_done_i && tx_remote_i && !sw_wr_i) |=> state_o == 4'b0010);

  assert_reply_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'b1111 && tx_done_i && !sw_wr_i) |=> state_o == 4'b1010);

  assert_rtr_answer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'b1010 && rtr_rx_i && !sw_wr_i) |=> state_o == 4'b1110);

  assert_unused_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && (sw_wdata_i[STATE_W-1:0] == 4'b1001 || sw_wdata_i[STATE_W-1:0] == 4'b1011))
      |=> state_o == 4'b1000);

  assert_sw_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && sw_wdata_i[STATE_W-1] && sw_wdata_i[STATE_W-1:0] != 4'b1001 &&
     sw_wdata_i[STATE_W-1:0] != 4'b1011) |=> state_o == $past(sw_wdata_i[STATE_W-1:0]));
endmodule

// File: tb/mbox_status_ctrl_tb_top.sv
module mbox_status_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr = 1'b0;
  logic [15:0] sw_wdata = '0;
  logic        accept = 1'b0, copy_done = 1'b0, tx_start = 1'b0;
  logic        tx_done = 1'b0, tx_remote = 1'b0, rtr_rx = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic [15:0] stat_word;
  logic [3:0]  state;
  logic        busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mbox_status_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
    .accept_i(accept), .copy_done_i(copy_done), .rx_dlc_i(rx_dlc),
    .tx_start_i(tx_start), .tx_done_i(tx_done), .tx_remote_i(tx_remote),
    .rtr_rx_i(rtr_rx), .stat_word_o(stat_word), .state_o(state), .busy_o(busy)
  );

  // busy codes per R12
  function automatic logic exp_busy(logic [3:0] s);
    return s inside {4'h1, 4'h3, 4'h5, 4'h7, 4'hD, 4'hF};
  endfunction

  // monitor: compare after each active edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (stat_word !== e || state !== e[3:0] || busy !== exp_busy(e[3:0])) begin
        bad++;
        $display("FAIL %s: word=%h state=%h busy=%b expected word=%h busy=%b",
                 t, stat_word, state, busy, e, exp_busy(e[3:0]));
      end
    end
  end

  // driver: inputs already set at negedge; push expectation for next edge
  task automatic cyc(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    sw_wr = 0; sw_wdata = '0; accept = 0; copy_done = 0; rx_dlc = '0;
    tx_start = 0; tx_done = 0; tx_remote = 0; rtr_rx = 0;
  endtask

  task automatic wr(input logic [15:0] w, input logic [15:0] exp, input string tag);
    sw_wr = 1; sw_wdata = w;
    cyc(exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (stat_word !== 16'h0000 || busy !== 1'b0) begin
      bad++;
      $display("FAIL R1: word=%h busy=%b expected word=0000 busy=0", stat_word, busy);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cyc(16'h0000, "R1 idle after reset");

    wr(16'h3F52, 16'h3052, "R2 write drops bits 11..8");
    accept = 1; cyc(16'h3053, "R3 ready->0011 R12 busy");
    cyc(16'h3053, "R3 hold without event");
    copy_done = 1; rx_dlc = 4'h8; cyc(16'h8054, "R4 first copy done");
    accept = 1; cyc(16'h8055, "R3 full->0101");
    copy_done = 1; rx_dlc = 4'h2; cyc(16'h2056, "R4 second copy done");
    accept = 1; cyc(16'h2057, "R3 overrun->0111");
    copy_done = 1; rx_dlc = 4'h7; cyc(16'h7056, "R4 overrun copy done");
    tx_start = 1; tx_done = 1; rtr_rx = 1; cyc(16'h7056, "R3 tx events ignored in rx state");

    wr(16'h1002, 16'h1002, "R2 write ready");
    accept = 1; cyc(16'h1003, "R3 accept");
    wr(16'h0000, 16'h0001, "R5 deactivate during copy");
    copy_done = 1; rx_dlc = 4'h9; cyc(16'h0000, "R5 busy code drains, dlc kept");
    accept = 1; cyc(16'h0000, "R3 accept ignored when off");

    wr(16'h0002, 16'h0002, "R2 write ready");
    accept = 1; cyc(16'h0003, "R3 accept");
    sw_wr = 1; sw_wdata = 16'h0000; copy_done = 1; rx_dlc = 4'h5;
    cyc(16'h0000, "R5 deactivate with copy done same cycle");

    wr(16'h0002, 16'h0002, "R2 write ready");
    sw_wr = 1; sw_wdata = 16'h0012; accept = 1;
    cyc(16'h0012, "R11 write beats accept");

    wr(16'h803C, 16'h803C, "R2 write send once");
    tx_start = 1; cyc(16'h803D, "R6 start R12 busy");
    tx_done = 1; cyc(16'h8038, "R6 done data frame");

    wr(16'h003C, 16'h003C, "R2 write send once");
    tx_start = 1; cyc(16'h003D, "R6 start");
    tx_done = 1; tx_remote = 1; cyc(16'h0032, "R7 remote request sent");

    wr(16'h0009, 16'h0008, "R10 code 1001");
    wr(16'h000B, 16'h0008, "R10 code 1011");

    wr(16'h001E, 16'h001E, "R2 write send once then reply");
    tx_start = 1; cyc(16'h001F, "R8 start R12 busy");
    tx_done = 1; cyc(16'h001A, "R8 done -> auto reply");
    accept = 1; tx_start = 1; cyc(16'h001A, "R3 accept ignored in 1010");
    rtr_rx = 1; cyc(16'h001E, "R9 remote request answered");
    tx_start = 1; cyc(16'h001F, "R8 reply start");
    tx_done = 1; cyc(16'h001A, "R8 back to waiting");
    sw_wr = 1; sw_wdata = 16'h4AC0; rtr_rx = 1; cyc(16'h40C0, "R11 write beats remote request");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule